// File: doc/BRIEF.md
# Boot Mode Capture and External Interrupt Pin Front-End

This block sits between a small group of shared package pins and the core. While reset is held it watches four request pins and a fifth, nonmaskable pin. On the clock where reset is seen released, it stores the four request pins as a 4-bit boot operating mode. At the same moment it stores the fifth pin as the start-up enable for the clock multiplier.

From the next cycle on, the same pins take a different role. The four pins become active-low external interrupt requests, and the fifth becomes a falling-edge nonmaskable request. Each request line can be set to either level or falling-edge detection, and each can be masked. The block presents pending flags to the core and accepts one-cycle acknowledge strobes.

It also produces two wake-up indications for the core's standby logic. Any active request ends the light wait state, whether or not it is masked. Only line A ends the deep stop state. Priority arbitration and vector fetch are left to the core.

Top module: `irq_pin_frontend`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block is held in its reset state from the next cycle. In that state `boot_mode` is 0, `boot_mode_vld` is 0, `pll_en_boot` is 0, `pend` is 0, `nmi_pend` is 0, and both wake outputs are 0.
- R2: The boot mode is captured at the first rising edge that sees `rst_n` high. Bit i of `boot_mode` equals the synchronized `pin_req_n[i]`, where bit 0 is line A and bit 3 is line D. `boot_mode_vld` rises at that edge. Pin changes while reset is held are not captured, and the mode stays stable until the next reset.
- R3: `pll_en_boot` is captured at the same edge from the synchronized `pin_nmi_n` level, where 1 means the clock multiplier starts enabled.
- R4: A line with `cfg_edge[i]`=0 is level-sensitive. Its request is active while its synchronized pin is low, and it follows the pin two rising edges after a pin change.
- R5: A line with `cfg_edge[i]`=1 is edge-triggered. A falling edge on its pin sets a sticky flag, which is visible three rising edges after the pin falls. The flag stays set after the pin returns high.
- R6: A one-cycle `ack[i]` clears the flag of line i at the next edge. If a new falling edge is detected at the same edge as the acknowledge, the flag stays set.
- R7: With `cfg_mask[i]`=1, `pend[i]` reads 0, but an edge flag is still recorded. Clearing the mask bit reveals that flag at once.
- R8: `wake_wait` is 1 whenever any of the four lines has an active request, regardless of its mask.
- R9: `wake_stop` is 1 only for an active request on line A (bit 0). Lines B, C and D never raise it.
- R10: A falling edge on `pin_nmi_n` sets `nmi_pend` three edges later. No mask bit affects it, and only `nmi_ack` clears it.
- R11: Falling edges that occur while reset is held, or at the release edge, set no flag on any line or on the nonmaskable input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_req_n | input | LINES | Shared mode / active-low request pins, bit 0 = line A |
| pin_nmi_n | input | 1 | Shared multiplier-enable / nonmaskable request pin |
| cfg_edge | input | LINES | Per-line detection mode, 1 = falling edge, 0 = level |
| cfg_mask | input | LINES | Per-line mask, 1 = hidden from core |
| ack | input | LINES | Per-line acknowledge strobe for edge flags |
| nmi_ack | input | 1 | Acknowledge strobe for the nonmaskable flag |
| boot_mode | output | LINES | Captured boot operating mode |
| boot_mode_vld | output | 1 | Boot mode has been captured since the last reset |
| pll_en_boot | output | 1 | Captured clock-multiplier start enable |
| pend | output | LINES | Unmasked pending requests toward the core |
| nmi_pend | output | 1 | Pending nonmaskable request |
| wake_stop | output | 1 | Wake from deep stop state |
| wake_wait | output | 1 | Wake from wait state |

## Verification
The bench builds the block with its defaults: four request lines and a two-stage synchronizer. With these values the level path has a latency of exactly two edges and the edge path exactly three, so an extra or missing register stage shows up as a miscompare. Four lines are enough to show that only bit 0 reaches `wake_stop`. They also allow a mask, an acknowledge and a fresh edge to be placed on different lines, or on the same line in the same cycle.

// File: rtl/irqfe_pkg.sv
package irqfe_pkg;

  // falling transition between two consecutive synchronized samples
  function automatic logic fell(input logic prev_s, input logic cur_s);
    return prev_s & ~cur_s;
  endfunction

  // sticky flag update: a new event wins over an acknowledge
  function automatic logic next_flag(input logic flag, input logic clr, input logic set);
    return set | (flag & ~clr);
  endfunction

  // request seen by the core before masking
  function automatic logic line_active(input logic edge_mode, input logic flag,
                                       input logic pin_s);
    return edge_mode ? flag : ~pin_s;
  endfunction

endpackage

// File: rtl/irqfe_sync.sv
module irqfe_sync #(
  parameter int unsigned W      = 5,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    stg[0] <= d;
    for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/irqfe_boot_latch.sv
module irqfe_boot_latch #(
  parameter int unsigned MODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_s,
  input  logic              pll_s,
  output logic [MODE_W-1:0] mode_q,
  output logic              mode_vld,
  output logic              pll_q,
  output logic              run
);
  logic in_rst;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_rst   <= 1'b1;
      mode_q   <= '0;
      mode_vld <= 1'b0;
      pll_q    <= 1'b0;
    end else if (in_rst) begin
      in_rst   <= 1'b0;
      mode_q   <= mode_s;
      mode_vld <= 1'b1;
      pll_q    <= pll_s;
    end
  end

  assign run = ~in_rst;
endmodule

// File: rtl/irqfe_line.sv
module irqfe_line
  import irqfe_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic pin_s,
  input  logic edge_mode,
  input  logic clr,
  output logic active,
  output logic flag,
  output logic fall_ev
);
  logic prev_s;

  always_ff @(posedge clk) prev_s <= pin_s;

  assign fall_ev = run & edge_mode & fell(prev_s, pin_s);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) flag <= 1'b0;
    else                flag <= next_flag(flag, clr, fall_ev);
  end

  assign active = run & line_active(edge_mode, flag, pin_s);
endmodule

// File: rtl/irq_pin_frontend.sv
module irq_pin_frontend
  import irqfe_pkg::*;
#(
  parameter int unsigned LINES       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] pin_req_n,
  input  logic             pin_nmi_n,
  input  logic [LINES-1:0] cfg_edge,
  input  logic [LINES-1:0] cfg_mask,
  input  logic [LINES-1:0] ack,
  input  logic             nmi_ack,
  output logic [LINES-1:0] boot_mode,
  output logic             boot_mode_vld,
  output logic             pll_en_boot,
  output logic [LINES-1:0] pend,
  output logic             nmi_pend,
  output logic             wake_stop,
  output logic             wake_wait
);
  localparam int unsigned PW = LINES + 1;

  logic [PW-1:0]    pins_s;
  logic [LINES-1:0] req_s;
  logic             nmi_s;
  logic             run;
  logic [LINES-1:0] active;
  logic [LINES-1:0] edge_flag;
  logic [LINES-1:0] fall_ev;
  logic             nmi_active;
  logic             nmi_flag;
  logic             nmi_fall;

  irqfe_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .d   ({pin_nmi_n, pin_req_n}),
    .q   (pins_s)
  );

  assign req_s = pins_s[LINES-1:0];
  assign nmi_s = pins_s[LINES];

  irqfe_boot_latch #(.MODE_W(LINES)) u_boot (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_s   (req_s),
    .pll_s    (nmi_s),
    .mode_q   (boot_mode),
    .mode_vld (boot_mode_vld),
    .pll_q    (pll_en_boot),
    .run      (run)
  );

  for (genvar i = 0; i < LINES; i++) begin : g_line
    irqfe_line u_line (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .pin_s     (req_s[i]),
      .edge_mode (cfg_edge[i]),
      .clr       (ack[i]),
      .active    (active[i]),
      .flag      (edge_flag[i]),
      .fall_ev   (fall_ev[i])
    );
  end

  irqfe_line u_nmi (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .pin_s     (nmi_s),
    .edge_mode (1'b1),
    .clr       (nmi_ack),
    .active    (nmi_active),
    .flag      (nmi_flag),
    .fall_ev   (nmi_fall)
  );

  assign pend      = active & ~cfg_mask;
  assign nmi_pend  = nmi_active;
  assign wake_wait = |active;
  assign wake_stop = active[0];
endmodule

// File: rtl/irqfe_checker.sv
module irqfe_checker #(
  parameter int unsigned LINES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LINES-1:0] cfg_mask,
  input logic [LINES-1:0] ack,
  input logic             nmi_ack,
  input logic [LINES-1:0] boot_mode,
  input logic             boot_mode_vld,
  input logic [LINES-1:0] pend,
  input logic             nmi_pend,
  input logic             wake_stop,
  input logic             wake_wait,
  input logic [LINES-1:0] edge_flag,
  input logic [LINES-1:0] fall_ev,
  input logic             nmi_flag
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!boot_mode_vld && boot_mode == '0 && pend == '0 && !nmi_pend && !wake_wait));

  a_r2_mode_stable: assert property (@(posedge clk) disable iff (!rst_n)
    boot_mode_vld |=> $stable(boot_mode));

  a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (|(edge_flag & ~ack)) |=>
      ((edge_flag & $past(edge_flag & ~ack)) == $past(edge_flag & ~ack)));

  a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ack & ~fall_ev)) |=> ((edge_flag & $past(ack & ~fall_ev)) == '0));

  a_r7_masked_hidden: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & cfg_mask) == '0);

  a_r8_pend_wakes: assert property (@(posedge clk) disable iff (!rst_n)
    (|pend) |-> wake_wait);

  a_r9_stop_implies_wait: assert property (@(posedge clk) disable iff (!rst_n)
    wake_stop |-> wake_wait);

  a_r10_nmi_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_pend && !nmi_ack) |=> nmi_pend);

  a_r11_clean_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(boot_mode_vld) |-> (edge_flag == '0 && !nmi_flag));
endmodule

bind irq_pin_frontend irqfe_checker #(.LINES(LINES)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_mask      (cfg_mask),
  .ack           (ack),
  .nmi_ack       (nmi_ack),
  .boot_mode     (boot_mode),
  .boot_mode_vld (boot_mode_vld),
  .pend          (pend),
  .nmi_pend      (nmi_pend),
  .wake_stop     (wake_stop),
  .wake_wait     (wake_wait),
  .edge_flag     (edge_flag),
  .fall_ev       (fall_ev),
  .nmi_flag      (nmi_flag)
);

// File: tb/sim_irq_pin_frontend.sv
`timescale 1ns/1ps
module sim_irq_pin_frontend;
  localparam int L       = 4;
  localparam int LAT_LVL = 2;
  localparam int LAT_EDG = 3;
  localparam int WD      = 20000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [L-1:0] pin_req_n = 4'b1010;
  logic         pin_nmi_n = 1'b0;
  logic [L-1:0] cfg_edge = '0;
  logic [L-1:0] cfg_mask = '0;
  logic [L-1:0] ack = '0;
  logic         nmi_ack = 1'b0;
  logic [L-1:0] boot_mode, pend;
  logic         boot_mode_vld, pll_en_boot, nmi_pend, wake_stop, wake_wait;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  irq_pin_frontend u0 (
    .clk(clk), .rst_n(rst_n), .pin_req_n(pin_req_n), .pin_nmi_n(pin_nmi_n),
    .cfg_edge(cfg_edge), .cfg_mask(cfg_mask), .ack(ack), .nmi_ack(nmi_ack),
    .boot_mode(boot_mode), .boot_mode_vld(boot_mode_vld), .pll_en_boot(pll_en_boot),
    .pend(pend), .nmi_pend(nmi_pend), .wake_stop(wake_stop), .wake_wait(wake_wait)
  );

  // level-mode vectors: {pins, mask, expected pend, expected wake_wait, expected wake_stop}
  localparam logic [13:0] VEC [6] = '{
    {4'b1111, 4'b0000, 4'b0000, 1'b0, 1'b0},
    {4'b1110, 4'b0000, 4'b0001, 1'b1, 1'b1},
    {4'b1101, 4'b0000, 4'b0010, 1'b1, 1'b0},
    {4'b0011, 4'b0100, 4'b1000, 1'b1, 1'b0},
    {4'b0000, 4'b1111, 4'b0000, 1'b1, 1'b1},
    {4'b0110, 4'b0001, 4'b1000, 1'b1, 1'b1}
  };

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == WD) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, WD);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    tick(6);
    chk("R1 vld", boot_mode_vld, 0);
    chk("R1 mode", boot_mode, 0);
    chk("R1 pend", {pend, nmi_pend, wake_wait, wake_stop}, 0);
    // R2: pin changes during reset are not captured
    pin_req_n = 4'b0101;
    tick(3);
    chk("R2 held", {boot_mode_vld, boot_mode}, 0);
    pin_req_n = 4'b1010;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    chk("R2 capture", {boot_mode_vld, boot_mode}, {1'b1, 4'b1010});
    chk("R3 pll off", pll_en_boot, 0);

    // R4 R7 R8 R9: level-mode vectors
    pin_nmi_n = 1'b1;
    for (int v = 0; v < 6; v++) begin
      pin_req_n = VEC[v][13:10];
      cfg_mask  = VEC[v][9:6];
      tick(LAT_LVL);
      chk("R4 R7 pend", pend, VEC[v][5:2]);
      chk("R8 wake_wait", wake_wait, VEC[v][1]);
      chk("R9 wake_stop", wake_stop, VEC[v][0]);
    end

    // edge mode
    cfg_edge = 4'b1111; cfg_mask = '0; pin_req_n = 4'b1111;
    tick(4);
    chk("R5 idle", pend, 0);
    pin_req_n = 4'b1101;
    tick(LAT_EDG);
    chk("R5 set", pend, 4'b0010);
    chk("R9 no stop from B", {wake_wait, wake_stop}, 2'b10);
    pin_req_n = 4'b1111;
    tick(4);
    chk("R5 sticky", pend, 4'b0010);
    ack = 4'b0010;
    tick(1);
    ack = '0;
    chk("R6 cleared", pend, 0);

    cfg_mask = 4'b0100; pin_req_n = 4'b1011;
    tick(LAT_EDG);
    chk("R7 masked", pend, 0);
    chk("R8 masked wake", {wake_wait, wake_stop}, 2'b10);
    cfg_mask = '0;
    #1;
    chk("R7 reveal", pend, 4'b0100);
    ack = 4'b0100; pin_req_n = 4'b1111;
    tick(1);
    ack = '0;
    chk("R6 clear C", pend, 0);

    // R6: edge at the same edge as acknowledge keeps the flag
    pin_req_n = 4'b0111;
    tick(2);
    ack = 4'b1000;
    tick(1);
    ack = '0;
    chk("R6 set wins", pend, 4'b1000);
    ack = 4'b1000; pin_req_n = 4'b1111;
    tick(1);
    ack = '0;
    tick(3);
    chk("R6 after rise", pend, 0);

    pin_req_n = 4'b1110;
    tick(LAT_EDG);
    chk("R9 stop from A", {pend, wake_stop}, {4'b0001, 1'b1});
    ack = 4'b0001; pin_req_n = 4'b1111;
    tick(1);
    ack = '0;

    // R10: nonmaskable edge
    cfg_mask = 4'b1111; pin_nmi_n = 1'b0;
    tick(LAT_EDG);
    chk("R10 set", nmi_pend, 1);
    pin_nmi_n = 1'b1;
    tick(3);
    chk("R10 sticky", nmi_pend, 1);
    nmi_ack = 1'b1;
    tick(1);
    nmi_ack = 1'b0;
    chk("R10 clear", nmi_pend, 0);
    cfg_mask = '0;

    // second reset: new mode, multiplier enabled
    rst_n = 1'b0; pin_req_n = 4'b0101; pin_nmi_n = 1'b1;
    tick(4);
    chk("R1 re-reset", {boot_mode_vld, pend, nmi_pend}, 0);
    rst_n = 1'b1;
    tick(1);
    chk("R2 mode2", boot_mode, 4'b0101);
    chk("R3 pll on", pll_en_boot, 1);

    // R11: falling edges inside reset are dropped
    rst_n = 1'b0; cfg_edge = 4'b1111; pin_req_n = 4'b1111; pin_nmi_n = 1'b1;
    tick(3);
    pin_req_n = 4'b0000; pin_nmi_n = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    chk("R2 mode3", {boot_mode, pll_en_boot}, 5'b00000);
    tick(LAT_EDG);
    chk("R11 no flags", {pend, nmi_pend, wake_wait}, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule